// File: doc/BRIEF.md
# Bidirectional Shift Register Clocked on Both Edges

This block is an eight-bit register that does one operation on every transition of its clock, rising and falling alike. On each edge it resets, loads a parallel word, shifts by one place toward either end, or holds. A fixed priority picks the operation: synchronous clear first, then parallel load, then shift (when enabled), and otherwise hold. Shifts toward the high end take a new bit from one serial input. Shifts toward the low end take a new bit from a second serial input.

No flip-flop in the design uses both clock edges. One bank of ordinary flops captures on the rising edge and a second bank captures on the falling edge. Each bank stores the wanted next value XORed with the other bank. The visible word is the XOR of the two banks, so it always equals the value written by the most recent edge. A separate asynchronous power-on clear sets both banks to zero.

Top module: `dual_edge_shreg`

## Requirements
- R1: The output word is updated on every rising and every falling clock edge, and each edge applies exactly one operation to the value left by the previous edge.
- R2: When `sync_clr` is 1 at an edge, the output becomes 0 after that edge, whatever the other inputs are.
- R3: When `sync_clr` is 0 and `load_en` is 1 at an edge, `par_out[i]` becomes `par_in[i]` for every bit i, whatever the level of `shift_en`.
- R4: When `sync_clr`, `load_en` and `shift_en` are all 0 at an edge, the output keeps its value.
- R5: When `shift_en` is 1, `sync_clr` and `load_en` are 0, and `dir_up` is 1, the new bit 0 is `ser_up_in` and the new bit n is the old bit n-1 for n = 1..7.
- R6: When `shift_en` is 1, `sync_clr` and `load_en` are 0, and `dir_up` is 0, the new bit 7 is `ser_down_in` and the new bit n is the old bit n+1 for n = 0..6.
- R7: While `por_clr` is 1 the output is 0 without waiting for a clock edge, and clock edges have no effect. Releasing `por_clr` leaves the output at 0 until the next clock edge.
- R8: The shift direction may change from one edge to the next. A rising-edge shift followed by a falling-edge shift the other way gives the composition of the two single shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both transitions are active |
| por_clr | input | 1 | Asynchronous power-on clear, active high |
| sync_clr | input | 1 | Synchronous clear, highest priority |
| load_en | input | 1 | Parallel load, does not depend on shift_en |
| shift_en | input | 1 | Enables shifting |
| dir_up | input | 1 | 1 = shift toward bit 7, 0 = shift toward bit 0 |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_down_in | input | 1 | Serial bit entering bit 7 on a downward shift |
| par_in | input | 8 | Parallel load word |
| par_out | output | 8 | Register contents |

## Verification
The bench aims at priority clashes: a clear asserted together with a load, and a load with shift enable low. A design with the wrong order would load over a clear, or ignore a load when shifting is disabled. The bench alternates directions on back-to-back edges and shifts on both edge polarities. A broken XOR pairing of the banks would show as a value lost or repeated on one edge type. The bench also asserts the power-on clear between edges and releases it away from any edge. A bank cleared late or only partly would then show a nonzero output or a glitch.

// File: rtl/des_pkg.sv
package des_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_UP    = 3'd1,
        OP_DOWN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } des_op_e;

endpackage

// File: rtl/des_op_decode.sv
module des_op_decode
    import des_pkg::*;
(
    input  logic    sync_clr,
    input  logic    load_en,
    input  logic    shift_en,
    input  logic    dir_up,
    output des_op_e op
);

    always_comb begin
        if (sync_clr) begin
            op = OP_CLEAR;
        end else if (load_en) begin
            op = OP_LOAD;
        end else if (shift_en) begin
            op = dir_up ? OP_UP : OP_DOWN;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/des_next_calc.sv
module des_next_calc
    import des_pkg::*;
#(
    parameter int W = 8
) (
    input  des_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   par_in,
    input  logic           ser_up_in,
    input  logic           ser_down_in,
    output logic [W-1:0]   nxt
);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = par_in;
            OP_UP:    nxt = {cur[W-2:0], ser_up_in};
            OP_DOWN:  nxt = {ser_down_in, cur[W-1:1]};
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/des_edge_bank.sv
module des_edge_bank #(
    parameter int W       = 8,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         por_clr,
    input  logic [W-1:0] want,
    input  logic [W-1:0] other,
    output logic [W-1:0] bank
);

    typedef struct packed {
        logic [W-1:0] mask;
    } bank_st_t;

    bank_st_t st_d;
    bank_st_t st_q;

    always_comb begin
        st_d.mask = want ^ other;
    end

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk or posedge por_clr) begin
                if (por_clr) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk or posedge por_clr) begin
                if (por_clr) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

    assign bank = st_q.mask;

endmodule

// File: rtl/dual_edge_shreg.sv
module dual_edge_shreg
    import des_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_clr,
    input  logic         sync_clr,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic         dir_up,
    input  logic         ser_up_in,
    input  logic         ser_down_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out
);

    des_op_e      op;
    logic [W-1:0] nxt;
    logic [W-1:0] rise_bank;
    logic [W-1:0] fall_bank;

    des_op_decode u_dec (
        .sync_clr (sync_clr),
        .load_en  (load_en),
        .shift_en (shift_en),
        .dir_up   (dir_up),
        .op       (op)
    );

    des_next_calc #(.W(W)) u_next (
        .op          (op),
        .cur         (par_out),
        .par_in      (par_in),
        .ser_up_in   (ser_up_in),
        .ser_down_in (ser_down_in),
        .nxt         (nxt)
    );

    des_edge_bank #(.W(W), .FALLING(1'b0)) u_rise (
        .clk     (clk),
        .por_clr (por_clr),
        .want    (nxt),
        .other   (fall_bank),
        .bank    (rise_bank)
    );

    des_edge_bank #(.W(W), .FALLING(1'b1)) u_fall (
        .clk     (clk),
        .por_clr (por_clr),
        .want    (nxt),
        .other   (rise_bank),
        .bank    (fall_bank)
    );

    assign par_out = rise_bank ^ fall_bank;

endmodule

// File: rtl/des_shreg_checker.sv
module des_shreg_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         por_clr,
    input logic         sync_clr,
    input logic         load_en,
    input logic         shift_en,
    input logic         dir_up,
    input logic         ser_up_in,
    input logic         ser_down_in,
    input logic [W-1:0] par_in,
    input logic [W-1:0] par_out
);

    typedef struct packed {
        logic         clr;
        logic         ld;
        logic         en;
        logic         up;
        logic         su;
        logic         sd;
        logic [W-1:0] d;
        logic [W-1:0] prev;
    } cap_t;

    cap_t cr_q;
    cap_t cf_q;
    logic vr_q;
    logic vf_q;

    always_ff @(posedge clk or posedge por_clr) begin
        if (por_clr) begin
            cr_q <= '0;
            vr_q <= 1'b0;
        end else begin
            cr_q <= '{sync_clr, load_en, shift_en, dir_up, ser_up_in, ser_down_in, par_in, par_out};
            vr_q <= 1'b1;
        end
    end

    always_ff @(negedge clk or posedge por_clr) begin
        if (por_clr) begin
            cf_q <= '0;
            vf_q <= 1'b0;
        end else begin
            cf_q <= '{sync_clr, load_en, shift_en, dir_up, ser_up_in, ser_down_in, par_in, par_out};
            vf_q <= 1'b1;
        end
    end

    // Result of a rising edge, seen at the following falling edge
    assert_rise_clear_R2: assert property (@(negedge clk) disable iff (por_clr)
        (vr_q && cr_q.clr) |-> (par_out == '0));
    assert_rise_load_R3: assert property (@(negedge clk) disable iff (por_clr)
        (vr_q && !cr_q.clr && cr_q.ld) |-> (par_out == cr_q.d));
    assert_rise_hold_R4: assert property (@(negedge clk) disable iff (por_clr)
        (vr_q && !cr_q.clr && !cr_q.ld && !cr_q.en) |-> (par_out == cr_q.prev));
    assert_rise_up_R5: assert property (@(negedge clk) disable iff (por_clr)
        (vr_q && !cr_q.clr && !cr_q.ld && cr_q.en && cr_q.up)
        |-> (par_out == {cr_q.prev[W-2:0], cr_q.su}));
    assert_rise_down_R6: assert property (@(negedge clk) disable iff (por_clr)
        (vr_q && !cr_q.clr && !cr_q.ld && cr_q.en && !cr_q.up)
        |-> (par_out == {cr_q.sd, cr_q.prev[W-1:1]}));

    // Result of a falling edge, seen at the following rising edge
    assert_fall_clear_R2: assert property (@(posedge clk) disable iff (por_clr)
        (vf_q && cf_q.clr) |-> (par_out == '0));
    assert_fall_load_R3: assert property (@(posedge clk) disable iff (por_clr)
        (vf_q && !cf_q.clr && cf_q.ld) |-> (par_out == cf_q.d));
    assert_fall_hold_R4: assert property (@(posedge clk) disable iff (por_clr)
        (vf_q && !cf_q.clr && !cf_q.ld && !cf_q.en) |-> (par_out == cf_q.prev));
    assert_fall_up_R5: assert property (@(posedge clk) disable iff (por_clr)
        (vf_q && !cf_q.clr && !cf_q.ld && cf_q.en && cf_q.up)
        |-> (par_out == {cf_q.prev[W-2:0], cf_q.su}));
    assert_fall_down_R6: assert property (@(posedge clk) disable iff (por_clr)
        (vf_q && !cf_q.clr && !cf_q.ld && cf_q.en && !cf_q.up)
        |-> (par_out == {cf_q.sd, cf_q.prev[W-1:1]}));

    assert_por_zero_R7: assert property (@(posedge clk)
        por_clr |-> (par_out == '0));

endmodule

bind dual_edge_shreg des_shreg_checker #(.W(W)) chk_i (
    .clk         (clk),
    .por_clr     (por_clr),
    .sync_clr    (sync_clr),
    .load_en     (load_en),
    .shift_en    (shift_en),
    .dir_up      (dir_up),
    .ser_up_in   (ser_up_in),
    .ser_down_in (ser_down_in),
    .par_in      (par_in),
    .par_out     (par_out)
);

// File: tb/dual_edge_shreg_tb_top.sv
`timescale 1ns/1ps
module dual_edge_shreg_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         por_clr = 1'b1;
    logic         sync_clr = 1'b0;
    logic         load_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         dir_up = 1'b0;
    logic         ser_up_in = 1'b0;
    logic         ser_down_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] exp_q = '0;
    bit last_up = 1'b0;
    bit last_shift = 1'b0;

    always #2.5 clk = ~clk;

    dual_edge_shreg #(.W(W)) dut_i (
        .clk(clk), .por_clr(por_clr), .sync_clr(sync_clr), .load_en(load_en),
        .shift_en(shift_en), .dir_up(dir_up), .ser_up_in(ser_up_in),
        .ser_down_in(ser_down_in), .par_in(par_in), .par_out(par_out)
    );

    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
        input logic c, input logic l, input logic e, input logic u,
        input logic su, input logic sd, input logic [W-1:0] d);
        if (c) return '0;
        if (l) return d;
        if (!e) return cur;
        if (u) return {cur[W-2:0], su};
        return {sd, cur[W-1:1]};
    endfunction

    function automatic string req_of(input logic c, input logic l,
        input logic e, input logic u);
        if (c) return "R2";
        if (l) return "R3";
        if (!e) return "R4";
        if (u) return "R5";
        return "R6";
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string rq);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: par_out=%02h expected %02h at %0t", rq, act, exp, $time);
        end
    endtask

    // Drive inputs, let one edge of either polarity pass, compare 1 ns later (R1)
    task automatic step(input logic c, input logic l, input logic e, input logic u,
        input logic su, input logic sd, input logic [W-1:0] d, input string force_tag);
        string rq;
        sync_clr = c; load_en = l; shift_en = e; dir_up = u;
        ser_up_in = su; ser_down_in = sd; par_in = d;
        @(clk);
        exp_q = model_next(exp_q, c, l, e, u, su, sd, d);
        rq = (force_tag != "") ? force_tag : req_of(c, l, e, u);
        // Direction flip on consecutive shift edges is the R8 case
        if (force_tag == "" && !c && !l && e && last_shift && (u != last_up)) rq = "R8";
        last_shift = !c && !l && e;
        last_up = u;
        #1;
        check(par_out, exp_q, rq);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: par_out=%02h expected completion", par_out);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        #1;
        check(par_out, '0, "R7");          // reset state under power-on clear
        #8;
        por_clr = 1'b0;                     // released between edges
        #0.5;
        check(par_out, '0, "R7");
        @(clk); #1;
        exp_q = '0;
        check(par_out, '0, "R4");

        // Directed corners
        step(0, 1, 0, 0, 0, 0, 8'hA5, "R3");   // load with shift enable low
        step(0, 0, 0, 1, 1, 1, 8'hFF, "R4");   // hold
        step(1, 1, 1, 1, 1, 1, 8'h3C, "R2");   // clear beats load
        step(0, 1, 1, 1, 1, 0, 8'h81, "R3");   // load beats shift
        step(0, 0, 1, 1, 1, 0, 8'h00, "R5");
        step(0, 0, 1, 0, 0, 1, 8'h00, "R8");
        step(0, 0, 1, 1, 0, 1, 8'h00, "R8");
        step(0, 0, 1, 0, 0, 0, 8'h00, "R8");
        for (int k = 0; k < 9; k++) step(0, 0, 1, 1, 1, 0, 8'h00, "R5");
        for (int k = 0; k < 9; k++) step(0, 0, 1, 0, 0, 0, 8'h00, "R6");
        step(0, 1, 0, 0, 0, 0, 8'h5A, "R1");
        step(0, 1, 0, 0, 0, 0, 8'hC3, "R1");

        // Mid-run power-on clear, asserted and released away from edges
        por_clr = 1'b1; sync_clr = 0; load_en = 1; par_in = 8'hFF;
        #0.5;
        check(par_out, '0, "R7");
        @(clk); #1;
        check(par_out, '0, "R7");           // edge has no effect
        por_clr = 1'b0;
        #0.5;
        check(par_out, '0, "R7");
        exp_q = '0;
        last_shift = 1'b0;

        // Constrained random phase with a fixed seed
        void'($urandom(32'h1DE5_0077));
        for (int k = 0; k < 600; k++) begin
            logic c, l, e;
            c = ($urandom % 16) == 0;
            l = ($urandom % 8) == 0;
            e = ($urandom % 4) != 0;
            step(c, l, e, 1'($urandom), 1'($urandom), 1'($urandom), W'($urandom), "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule